// File: doc/BRIEF.md
# Constant-Time Priority Ready-Queue Selector

This block chooses the next task for one processor core. Ready task IDs are kept in FIFO lists, one list per priority level, and every level has two lists: one in the active set and one in the expired set. A request for the next task returns the head of the most urgent non-empty list in the active set. Level 0 is the most urgent. The task is removed from its list as it is returned. The search runs over a per-set occupancy bitmap and never over the tasks, so the answer always comes back exactly one clock after the request, however many tasks are queued.

A task that has used up its time slice comes back through its own port with a freshly computed priority, and it is appended to the expired set. A request can find the active set empty while the expired set still holds tasks. In that case the two sets trade roles in the same cycle and the pick is taken from the new active set. The trade flips a single register bit, so no list contents move. The lists are threaded through a shared next-pointer memory indexed by task ID, with a head and a tail register for each list.

Top module: `rq_o1_sched`

## Requirements
- R1: After reset no task is queued: `all_empty` is 1, and `rsp_valid` and `ins_err` are 0.
- R2: A `pick_req` high at a clock edge gives `rsp_valid`=1 at the next edge. When a task is returned, `rsp_idle`=0 and `rsp_id`/`rsp_prio` carry the head of the lowest-numbered non-empty active list, and that task leaves the queue.
- R3: Tasks at the same level of the same set are returned in the order they were inserted.
- R4: `enq_expired`=0 appends to the active set and `enq_expired`=1 appends to the expired set. Expired tasks are never returned while the active set holds any task, whatever their levels.
- R5: `slice_done` appends `slice_id` to the expired set at level `slice_prio`.
- R6: If a request finds the active set empty and the expired set non-empty, the sets swap roles in that cycle and the request returns the top task of the newly active set.
- R7: A request made when both sets are empty returns `rsp_valid`=1, `rsp_idle`=1, `rsp_id`=0 and `rsp_prio`=0.
- R8: Inserting an ID that is already queued pulses `ins_err` one cycle later and leaves every list unchanged.
- R9: If `enq_valid` and `slice_done` are high in the same cycle, only the slice-expiry insert is applied, and `ins_err` pulses one cycle later.
- R10: In a cycle that carries both a request and an insert, the request sees only the tasks queued before that cycle. The insert is applied afterwards, and "active" or "expired" refers to the roles those sets hold after any swap made in that cycle.
- R11: `all_empty` is 1 exactly when neither set holds a task, as of the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Insert a ready task |
| enq_id | input | 6 | ID of the task to insert |
| enq_prio | input | 5 | Level of the task to insert (0 most urgent) |
| enq_expired | input | 1 | 1: insert into the expired set, 0: into the active set |
| slice_done | input | 1 | A task has used up its time slice |
| slice_id | input | 6 | ID of the expiring task |
| slice_prio | input | 5 | Recomputed level of the expiring task |
| pick_req | input | 1 | Request the next task to run |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_idle | output | 1 | Response carries no task |
| rsp_id | output | 6 | ID of the returned task |
| rsp_prio | output | 5 | Level of the returned task |
| ins_err | output | 1 | The previous cycle's insert was rejected |
| all_empty | output | 1 | Both sets hold no task |

## Verification
Removal and insertion can fall in the same cycle. The most delicate cases are an insert into the very list whose last task is being popped, and an insert that arrives in the cycle where the request swaps the sets. The directed sequences create both cases on purpose, and a long random phase with requests, inserts and expiries all overlapping keeps producing them again. A behavioural model built from per-list queues and a role index predicts every response, error pulse and empty flag, and it is compared with the outputs on every clock.

// File: rtl/rq_pkg.sv
package rq_pkg;
   typedef enum logic [0:0] {
      RQ_TO_ACTIVE  = 1'b0,
      RQ_TO_EXPIRED = 1'b1
   } rq_target_e;
endpackage

// File: rtl/rq_first_set.sv
module rq_first_set #(
   parameter int unsigned N = 32,
   localparam int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] vec,
   output logic         any,
   output logic [W-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("rq_first_set: N must be at least 2");
   end

   // lowest set index wins: level 0 is the most urgent
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = W'(i);
      end
   end

   assign any = |vec;
endmodule

// File: rtl/rq_link_ram.sv
module rq_link_ram #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [AW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [AW-1:0] rdata
);
   logic [AW-1:0] link [DEPTH];

   always_ff @(posedge clk) begin
      if (we) link[waddr] <= wdata;
   end

   assign rdata = link[raddr];
endmodule

// File: rtl/rq_member.sv
module rq_member #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [AW-1:0] set_id,
   input  logic          clr_en,
   input  logic [AW-1:0] clr_id,
   input  logic [AW-1:0] ask_id,
   output logic          hit
);
   logic [DEPTH-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
      end else begin
         if (clr_en) held[clr_id] <= 1'b0;
         if (set_en) held[set_id] <= 1'b1;
      end
   end

   assign hit = held[ask_id];

   AST_POP_WAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> held[clr_id]);                                  // R2
   AST_SET_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !held[set_id]);                                 // R8
endmodule

// File: rtl/rq_o1_sched.sv
module rq_o1_sched
   import rq_pkg::*;
#(
   parameter int unsigned NUM_PRIO = 32,
   parameter int unsigned NUM_TASK = 64,
   localparam int unsigned PW = $clog2(NUM_PRIO),
   localparam int unsigned IW = $clog2(NUM_TASK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enq_valid,
   input  logic [IW-1:0] enq_id,
   input  logic [PW-1:0] enq_prio,
   input  logic          enq_expired,
   input  logic          slice_done,
   input  logic [IW-1:0] slice_id,
   input  logic [PW-1:0] slice_prio,
   input  logic          pick_req,
   output logic          rsp_valid,
   output logic          rsp_idle,
   output logic [IW-1:0] rsp_id,
   output logic [PW-1:0] rsp_prio,
   output logic          ins_err,
   output logic          all_empty
);
   if ((32'(1) << PW) != NUM_PRIO || NUM_PRIO < 2) begin : g_bad_prio
      $error("rq_o1_sched: NUM_PRIO must be a power of two, at least 2");
   end
   if ((32'(1) << IW) != NUM_TASK || NUM_TASK < 2) begin : g_bad_task
      $error("rq_o1_sched: NUM_TASK must be a power of two, at least 2");
   end

   localparam logic [NUM_PRIO-1:0] ONE = NUM_PRIO'(1);

   // sel names which of the two list sets currently plays the active role
   logic                sel;
   logic [NUM_PRIO-1:0] bm [2];
   logic [IW-1:0]       hd [2][NUM_PRIO];
   logic [IW-1:0]       tl [2][NUM_PRIO];

   logic [1:0]          set_any;
   logic [PW-1:0]       set_top [2];

   for (genvar s = 0; s < 2; s++) begin : g_enc
      rq_first_set #(.N(NUM_PRIO)) u_enc (
         .vec (bm[s]),
         .any (set_any[s]),
         .idx (set_top[s])
      );
   end

   // selection side
   logic                act_any, exp_any, do_swap, sel_n, do_pop, pop_last;
   logic [PW-1:0]       pop_prio;
   logic [IW-1:0]       pop_id, pop_nxt;
   logic [NUM_PRIO-1:0] act_vec, lowmask;

   assign act_any  = set_any[sel];
   assign exp_any  = set_any[~sel];
   assign do_swap  = pick_req & ~act_any & exp_any;
   assign sel_n    = sel ^ do_swap;
   assign do_pop   = pick_req & (|set_any);
   assign pop_prio = set_top[sel_n];
   assign pop_id   = hd[sel_n][pop_prio];
   assign pop_last = (pop_id == tl[sel_n][pop_prio]);
   assign act_vec  = bm[sel_n];
   assign lowmask  = (ONE << pop_prio) - ONE;

   // insertion side: slice expiry wins over a plain enqueue
   rq_target_e    ins_tgt;
   logic          ins_req, ins_ok, ins_set, ins_had, dup, same_list, fresh_head;
   logic [IW-1:0] ins_id;
   logic [PW-1:0] ins_prio;

   assign ins_req  = enq_valid | slice_done;
   assign ins_id   = slice_done ? slice_id   : enq_id;
   assign ins_prio = slice_done ? slice_prio : enq_prio;
   assign ins_tgt  = (slice_done | enq_expired) ? RQ_TO_EXPIRED : RQ_TO_ACTIVE;
   assign ins_set  = sel_n ^ (ins_tgt == RQ_TO_EXPIRED);
   assign ins_ok   = ins_req & ~dup;
   assign ins_had  = bm[ins_set][ins_prio];
   assign same_list  = do_pop & ins_ok & (ins_set == sel_n) & (ins_prio == pop_prio);
   assign fresh_head = ~ins_had | (same_list & pop_last);

   rq_member #(.DEPTH(NUM_TASK)) u_member (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (ins_ok),
      .set_id (ins_id),
      .clr_en (do_pop),
      .clr_id (pop_id),
      .ask_id (ins_id),
      .hit    (dup)
   );

   rq_link_ram #(.DEPTH(NUM_TASK)) u_link (
      .clk   (clk),
      .we    (ins_ok & ins_had),
      .waddr (tl[ins_set][ins_prio]),
      .wdata (ins_id),
      .raddr (pop_id),
      .rdata (pop_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel   <= 1'b0;
         bm[0] <= '0;
         bm[1] <= '0;
      end else begin
         sel <= sel_n;
         if (do_pop && pop_last) bm[sel_n][pop_prio] <= 1'b0;
         if (ins_ok)             bm[ins_set][ins_prio] <= 1'b1;
      end
   end

   // list pointers are only read behind a set bitmap bit
   always_ff @(posedge clk) begin
      if (do_pop && !pop_last) hd[sel_n][pop_prio] <= pop_nxt;
      if (ins_ok) begin
         tl[ins_set][ins_prio] <= ins_id;
         if (fresh_head) hd[ins_set][ins_prio] <= ins_id;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_idle  <= 1'b0;
         rsp_id    <= '0;
         rsp_prio  <= '0;
         ins_err   <= 1'b0;
      end else begin
         rsp_valid <= pick_req;
         rsp_idle  <= pick_req & ~do_pop;
         rsp_id    <= do_pop ? pop_id   : '0;
         rsp_prio  <= do_pop ? pop_prio : '0;
         ins_err   <= (ins_req & dup) | (enq_valid & slice_done);
      end
   end

   assign all_empty = ~(|set_any);

   AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pick_req |=> rsp_valid);                                   // R2
   AST_PICK_MOST_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
      do_pop |-> (act_vec[pop_prio] && (act_vec & lowmask) == '0)); // R2
   AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_req && all_empty) |=> rsp_idle);                     // R7
   AST_TASK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_req && !all_empty) |=> !rsp_idle);                   // R6
   AST_SWAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_req && !act_any && exp_any) |=> (sel != $past(sel))); // R6
   AST_ROLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(pick_req && !act_any) |=> $stable(sel));                 // R6
   AST_CLASH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && slice_done) |=> ins_err);                    // R9
endmodule

// File: tb/sim_rq_o1_sched.sv
module sim_rq_o1_sched;
   localparam int PERIOD = 10;
   localparam int NP = 32;
   localparam int NT = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enq_valid = 1'b0, enq_expired = 1'b0, slice_done = 1'b0, pick_req = 1'b0;
   logic [5:0] enq_id = '0, slice_id = '0;
   logic [4:0] enq_prio = '0, slice_prio = '0;
   logic       rsp_valid, rsp_idle, ins_err, all_empty;
   logic [5:0] rsp_id;
   logic [4:0] rsp_prio;

   always #(PERIOD / 2) clk = ~clk;

   rq_o1_sched #(.NUM_PRIO(NP), .NUM_TASK(NT)) u0 (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_id(enq_id), .enq_prio(enq_prio), .enq_expired(enq_expired),
      .slice_done(slice_done), .slice_id(slice_id), .slice_prio(slice_prio),
      .pick_req(pick_req),
      .rsp_valid(rsp_valid), .rsp_idle(rsp_idle), .rsp_id(rsp_id), .rsp_prio(rsp_prio),
      .ins_err(ins_err), .all_empty(all_empty)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string phase = "R2";

   // behavioural model: one queue per (set, level), plus a role index
   logic [5:0] mq [2*NP][$];
   bit         inq [NT];
   int         act = 0;

   task automatic chk(string tag, string what, int a, int e);
      checks++;
      if (a != e) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, a, e);
      end
   endtask

   function automatic int top_level(int s);
      for (int p = 0; p < NP; p++) if (mq[s*NP+p].size() > 0) return p;
      return -1;
   endfunction

   task automatic cyc(bit pk, bit ev, int eid, int ep, bit ex, bit xv, int xid, int xp);
      bit    swapped, dup, ins, e_idle, e_err, e_empty;
      int    iid, ip, iset, p, e_id, e_prio;
      string tag_rsp, tag_err;
      swapped = 0; e_idle = 0; e_id = 0; e_prio = 0;
      pick_req = pk; enq_valid = ev; enq_id = eid[5:0]; enq_prio = ep[4:0]; enq_expired = ex;
      slice_done = xv; slice_id = xid[5:0]; slice_prio = xp[4:0];
      ins  = ev || xv;
      iid  = xv ? xid : eid;
      ip   = xv ? xp : ep;
      dup  = ins && inq[iid];
      e_err = (ev && xv) || dup;
      tag_err = (ev && xv) ? "R9" : "R8";
      if (pk) begin
         if (top_level(act) < 0 && top_level(1 - act) >= 0) begin
            act = 1 - act;
            swapped = 1;
         end
         p = top_level(act);
         if (p < 0) e_idle = 1;
         else begin
            e_id = int'(mq[act*NP+p].pop_front());
            e_prio = p;
            inq[e_id] = 0;
         end
      end
      tag_rsp = e_idle ? "R7" : (swapped ? "R6" : phase);
      if (ins && !dup) begin
         iset = (xv || ex) ? 1 - act : act;
         mq[iset*NP+ip].push_back(iid[5:0]);
         inq[iid] = 1;
      end
      e_empty = 1;
      for (int k = 0; k < 2 * NP; k++) if (mq[k].size() > 0) e_empty = 0;
      @(negedge clk);
      chk(tag_rsp, "rsp_valid", int'(rsp_valid), int'(pk));
      if (pk) begin
         chk(tag_rsp, "rsp_idle", int'(rsp_idle), int'(e_idle));
         chk(tag_rsp, "rsp_id", int'(rsp_id), e_id);
         chk(tag_rsp, "rsp_prio", int'(rsp_prio), e_prio);
      end
      chk(tag_err, "ins_err", int'(ins_err), int'(e_err));
      chk("R11", "all_empty", int'(all_empty), int'(e_empty));
   endtask

   task automatic pick();
      cyc(1, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic put(int id, int pr, bit toexp);
      cyc(0, 1, id, pr, toexp, 0, 0, 0);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "all_empty", int'(all_empty), 1);
      chk("R1", "rsp_valid", int'(rsp_valid), 0);
      chk("R1", "ins_err", int'(ins_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      pick();                                   // R7 on a fresh queue

      phase = "R3";                             // FIFO at one level
      put(1, 7, 0); put(2, 7, 0); put(3, 7, 0);
      pick(); pick(); pick();

      phase = "R4";                             // expired hidden behind active
      put(10, 2, 1); put(11, 20, 0);
      pick(); pick(); pick();                   // 11, then swap to 10 (R6), then idle

      phase = "R5";                             // slice expiry into expired set
      cyc(0, 0, 0, 0, 0, 1, 20, 4);
      put(21, 9, 0);
      pick(); pick();

      phase = "R8";                             // duplicate insert rejected
      put(5, 3, 0); put(5, 1, 0); put(5, 3, 1);
      pick(); pick();

      phase = "R9";                             // enqueue and expiry together
      cyc(0, 1, 6, 0, 0, 1, 7, 8);
      pick(); pick();

      phase = "R10";                            // pick and insert together
      put(30, 0, 0);
      cyc(1, 1, 31, 0, 0, 0, 0, 0);             // pop last of list, append same list
      pick();
      cyc(0, 0, 0, 0, 0, 1, 40, 1);
      cyc(1, 1, 41, 1, 0, 0, 0, 0);             // swap and insert in one cycle
      pick(); pick();
      cyc(1, 1, 42, 3, 0, 0, 0, 0);             // request on empty sees no insert
      pick();

      phase = "R2";                             // random overlap of all functions
      for (int n = 0; n < 4000; n++) begin
         cyc(($urandom % 2) == 0, ($urandom % 3) != 0, int'($urandom % NT), int'($urandom % 8),
             ($urandom % 2) == 0, ($urandom % 5) == 0, int'($urandom % NT), int'($urandom % 8));
      end
      while (top_level(0) >= 0 || top_level(1) >= 0) pick();
      pick();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule